// File: doc/BRIEF.md
# Read/Write Drain Arbiter with Occupancy Hysteresis

This block sits at the front of a memory controller channel and decides, once per cycle, which pending request to hand to the command issue logic. Reads wait in a queue kept in arrival order; writes wait in a second queue of their own. Each cycle the issue logic reports, position by position, which queued entries could legally issue now. The arbiter turns that report into at most one grant, tagged as read or write, with the entry's queue position and address.

Normally reads are favoured, and the oldest issuable read wins. Writes pile up until the write queue holds more than a high mark. At that point the arbiter switches to a drain mode that serves only writes, oldest issuable first. It stays in drain mode until the write occupancy has dropped to a low mark. The gap between the two marks keeps the arbiter from switching back and forth too often. When the read queue is empty, writes are also served in read mode, so idle read cycles are not wasted.

Both queues close the gap left by a grant so that arrival order is kept. A push into a full queue is refused, and the queue's full flag stays high while it is full.

Top module: `rwd_arbiter`

## Requirements
- R1: While reset is held (synchronous, active low), and in the first cycle after it, both queues are empty, no grant is given, the mode output is 0 (read mode) and both full flags are 0.
- R2: In read mode with reads pending, the grant goes to the read at the lowest queue position (position 0 is the oldest) whose issuable bit is set. The grant shows gnt_write=0, gnt_idx set to that position and gnt_addr set to its address.
- R3: After any grant, the entries behind the granted one move up one position and keep their relative order. Their later grants therefore present addresses in arrival order.
- R4: The mode output becomes 1 (drain) in the cycle after one in which the write occupancy is strictly greater than HI_MARK (default 40).
- R5: Drain mode persists while write occupancy exceeds LO_MARK (default 20). The mode returns to 0 in the cycle after one in which drain mode saw occupancy at or below LO_MARK.
- R6: In drain mode only writes are granted (gnt_write=1), the oldest issuable write first, whatever the read issuable bits are.
- R7: In read mode with an empty read queue, the oldest issuable write is granted.
- R8: In read mode with reads pending but none of them issuable, no grant is given, even when writes are issuable.
- R9: A queue holding its full capacity (16 reads, 64 writes by default) raises its full flag. A push into it is refused, and the refused address never appears in a later grant.
- R10: Issuable bits at positions at or beyond the current occupancy of a queue have no effect on the grant.
- R11: At most one grant is given per cycle. A push and a grant on the same queue in the same cycle are both applied: the granted entry leaves and the new one joins at the tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_push | input | 1 | Enqueue strobe for the read queue |
| rd_push_addr | input | ADDR_W | Address of the read being enqueued |
| wr_push | input | 1 | Enqueue strobe for the write queue |
| wr_push_addr | input | ADDR_W | Address of the write being enqueued |
| rd_ready | input | RD_DEPTH | Issuable bit for each read queue position, bit 0 = oldest |
| wr_ready | input | WR_DEPTH | Issuable bit for each write queue position, bit 0 = oldest |
| gnt_valid | output | 1 | A grant is given this cycle; the entry leaves its queue at the clock edge |
| gnt_write | output | 1 | 1 when the grant is a write, 0 for a read |
| gnt_idx | output | IDX_W | Queue position of the granted entry |
| gnt_addr | output | ADDR_W | Address of the granted entry |
| drain_mode | output | 1 | 1 while in write-drain mode |
| rd_full | output | 1 | Read queue holds RD_DEPTH entries |
| wr_full | output | 1 | Write queue holds WR_DEPTH entries |

## Verification
The hardest states to reach are at the top of the write queue. Here drain mode, a full queue and a refused push all have to line up, and the exit from drain has to be seen as occupancy crosses the low mark. Random traffic with no bias rarely holds enough writes back. So a directed phase keeps every write non-issuable while pushing 66 writes, past the high mark and into the full queue. It then opens all issuable bits on both queues and watches writes win over ready reads all the way down to the low mark. A biased random phase follows. It pushes writes often and makes them issuable only in about one cycle in four, so drain entry and exit happen many times while reads and writes arrive in the same cycles as grants.

// File: rtl/rwd_pkg.sv
// Shared types for the read/write drain arbiter.
// Assumes: nothing beyond the two service modes.
package rwd_pkg;

    typedef enum logic {
        ARB_READ  = 1'b0,
        ARB_DRAIN = 1'b1
    } arb_mode_e;

endpackage

// File: rtl/rwd_order_queue.sv
// Arrival-ordered request queue with compaction.
// Position 0 holds the oldest entry. A pop removes any position; everything
// behind it moves up one slot, and a push lands at the tail after the pop.
// Assumes: pop_idx < count whenever pop is high. A push into a full queue is
// dropped, even if a pop happens in the same cycle.
module rwd_order_queue #(
    parameter  int DEPTH  = 16,
    parameter  int ADDR_W = 16,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           push,
    input  logic [ADDR_W-1:0]              push_addr,
    input  logic                           pop,
    input  logic [IDX_W-1:0]               pop_idx,
    output logic [DEPTH-1:0]               valid,
    output logic [DEPTH-1:0][ADDR_W-1:0]   slot_addr,
    output logic [CNT_W-1:0]               count,
    output logic                           full
);

    logic [DEPTH-1:0][ADDR_W-1:0] slot_q;
    logic [DEPTH-1:0][ADDR_W-1:0] slot_d;
    logic [DEPTH:0][ADDR_W-1:0]   slot_ext;
    logic [CNT_W-1:0]             cnt_q;
    logic [CNT_W-1:0]             cnt_after_pop;
    logic                         push_ok;

    assign full          = (cnt_q == CNT_W'(DEPTH));
    assign push_ok       = push && !full;
    assign cnt_after_pop = cnt_q - CNT_W'(pop);
    assign slot_ext      = {ADDR_W'(0), slot_q};
    assign slot_addr     = slot_q;
    assign count         = cnt_q;

    // Next slot contents: close the gap at pop_idx, then write the tail.
    always_comb begin
        slot_d = slot_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (pop && (i >= int'(pop_idx))) begin
                slot_d[i] = slot_ext[i+1];
            end
            if (push_ok && (i == int'(cnt_after_pop))) begin
                slot_d[i] = push_addr;
            end
        end
    end

    // Occupancy mask: the positions below the count hold live entries.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            valid[i] = (i < int'(cnt_q));
        end
    end

    // State update for the slots and the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
            cnt_q  <= '0;
        end else begin
            slot_q <= slot_d;
            cnt_q  <= cnt_after_pop + CNT_W'(push_ok);
        end
    end

endmodule

// File: rtl/rwd_oldest_pick.sv
// Finds the lowest set bit of a candidate vector, which is the oldest
// eligible queue position.
// Assumes: bit 0 is the oldest position.
module rwd_oldest_pick #(
    parameter int N     = 16,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     cand,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    // Walk from newest to oldest so the last hit is the oldest.
    always_comb begin
        found = |cand;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/rwd_drain_ctrl.sv
// Two-mark hysteresis for the service mode.
// Enters drain when write occupancy is above HI_MARK and leaves it once
// occupancy is at or below LO_MARK. Decisions use the registered count, so
// each change shows one cycle after its condition.
// Assumes: LO_MARK < HI_MARK < queue depth.
module rwd_drain_ctrl
    import rwd_pkg::*;
#(
    parameter int CNT_W   = 7,
    parameter int HI_MARK = 40,
    parameter int LO_MARK = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] wr_count,
    output arb_mode_e        mode
);

    arb_mode_e mode_q;
    arb_mode_e mode_d;

    assign mode = mode_q;

    // Next mode from the current mode and the write occupancy.
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            ARB_READ:  if (wr_count >  CNT_W'(HI_MARK)) mode_d = ARB_DRAIN;
            ARB_DRAIN: if (wr_count <= CNT_W'(LO_MARK)) mode_d = ARB_READ;
            default:   mode_d = ARB_READ;
        endcase
    end

    // Mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= ARB_READ;
        end else begin
            mode_q <= mode_d;
        end
    end

endmodule

// File: rtl/rwd_arbiter.sv
// Read/write arbiter for a memory channel front end.
// Serves the oldest issuable read in read mode and the oldest issuable
// write in drain mode, or in read mode when no read is queued. Gives at
// most one grant per cycle; the granted entry leaves its queue at the clock edge.
// Assumes: issuable vectors are indexed by queue position, bit 0 oldest.
module rwd_arbiter
    import rwd_pkg::*;
#(
    parameter  int RD_DEPTH = 16,
    parameter  int WR_DEPTH = 64,
    parameter  int ADDR_W   = 16,
    parameter  int HI_MARK  = 40,
    parameter  int LO_MARK  = 20,
    localparam int RD_IDX_W = $clog2(RD_DEPTH),
    localparam int WR_IDX_W = $clog2(WR_DEPTH),
    localparam int IDX_W    = (RD_IDX_W > WR_IDX_W) ? RD_IDX_W : WR_IDX_W,
    localparam int RD_CNT_W = $clog2(RD_DEPTH + 1),
    localparam int WR_CNT_W = $clog2(WR_DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_push,
    input  logic [ADDR_W-1:0]   rd_push_addr,
    input  logic                wr_push,
    input  logic [ADDR_W-1:0]   wr_push_addr,
    input  logic [RD_DEPTH-1:0] rd_ready,
    input  logic [WR_DEPTH-1:0] wr_ready,
    output logic                gnt_valid,
    output logic                gnt_write,
    output logic [IDX_W-1:0]    gnt_idx,
    output logic [ADDR_W-1:0]   gnt_addr,
    output logic                drain_mode,
    output logic                rd_full,
    output logic                wr_full
);

    if (LO_MARK >= HI_MARK || HI_MARK >= WR_DEPTH) begin : g_bad_marks
        $error("rwd_arbiter: need LO_MARK < HI_MARK < WR_DEPTH");
    end

    logic [RD_DEPTH-1:0]             rd_valid;
    logic [RD_DEPTH-1:0][ADDR_W-1:0] rd_slots;
    logic [RD_CNT_W-1:0]             rd_cnt;
    logic [WR_DEPTH-1:0]             wr_valid;
    logic [WR_DEPTH-1:0][ADDR_W-1:0] wr_slots;
    logic [WR_CNT_W-1:0]             wr_cnt;

    logic                rd_found, wr_found;
    logic [RD_IDX_W-1:0] rd_pick;
    logic [WR_IDX_W-1:0] wr_pick;
    logic                serve_wr;
    logic                rd_pop, wr_pop;
    arb_mode_e           mode;

    rwd_order_queue #(.DEPTH(RD_DEPTH), .ADDR_W(ADDR_W)) u_rdq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rd_push),
        .push_addr (rd_push_addr),
        .pop       (rd_pop),
        .pop_idx   (rd_pick),
        .valid     (rd_valid),
        .slot_addr (rd_slots),
        .count     (rd_cnt),
        .full      (rd_full)
    );

    rwd_order_queue #(.DEPTH(WR_DEPTH), .ADDR_W(ADDR_W)) u_wrq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_push),
        .push_addr (wr_push_addr),
        .pop       (wr_pop),
        .pop_idx   (wr_pick),
        .valid     (wr_valid),
        .slot_addr (wr_slots),
        .count     (wr_cnt),
        .full      (wr_full)
    );

    rwd_oldest_pick #(.N(RD_DEPTH), .IDX_W(RD_IDX_W)) u_rdpick (
        .cand  (rd_ready & rd_valid),
        .found (rd_found),
        .idx   (rd_pick)
    );

    rwd_oldest_pick #(.N(WR_DEPTH), .IDX_W(WR_IDX_W)) u_wrpick (
        .cand  (wr_ready & wr_valid),
        .found (wr_found),
        .idx   (wr_pick)
    );

    rwd_drain_ctrl #(.CNT_W(WR_CNT_W), .HI_MARK(HI_MARK), .LO_MARK(LO_MARK)) u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_count (wr_cnt),
        .mode     (mode)
    );

    assign drain_mode = (mode == ARB_DRAIN);

    // Choose the queue to serve: writes in drain mode or when no read waits.
    always_comb begin
        serve_wr  = (mode == ARB_DRAIN) || (rd_cnt == '0);
        gnt_write = serve_wr;
        gnt_valid = serve_wr ? wr_found : rd_found;
        rd_pop    = gnt_valid && !serve_wr;
        wr_pop    = gnt_valid &&  serve_wr;
    end

    // Present the index and address of the chosen entry.
    always_comb begin
        if (serve_wr) begin
            gnt_idx  = IDX_W'(wr_pick);
            gnt_addr = wr_slots[wr_pick];
        end else begin
            gnt_idx  = IDX_W'(rd_pick);
            gnt_addr = rd_slots[rd_pick];
        end
    end

endmodule

// File: rtl/rwd_arbiter_chk.sv
// Property checker for rwd_arbiter, bound to every instance.
// Assumes: connected to the occupancy counts inside the top module.
module rwd_arbiter_chk #(
    parameter int RD_DEPTH = 16,
    parameter int WR_DEPTH = 64,
    parameter int HI_MARK  = 40,
    parameter int LO_MARK  = 20,
    parameter int IDX_W    = 6,
    parameter int RD_CNT_W = 5,
    parameter int WR_CNT_W = 7
) (
    input logic                clk,
    input logic                rst_n,
    input logic                gnt_valid,
    input logic                gnt_write,
    input logic [IDX_W-1:0]    gnt_idx,
    input logic                drain_mode,
    input logic [RD_DEPTH-1:0] rd_ready,
    input logic [RD_CNT_W-1:0] rd_cnt,
    input logic [WR_CNT_W-1:0] wr_cnt,
    input logic                wr_full,
    input logic                wr_push
);

    // R2
    rd_grant_issuable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && !gnt_write) |-> (rd_ready[gnt_idx] && (int'(gnt_idx) < int'(rd_cnt))));

    // R4
    drain_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drain_mode) |-> (int'($past(wr_cnt)) > HI_MARK));

    // R5
    drain_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drain_mode) |-> (int'($past(wr_cnt)) <= LO_MARK));

    // R6
    drain_writes_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_mode && gnt_valid) |-> gnt_write);

    // R9
    full_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_full && wr_push && !(gnt_valid && gnt_write)) |=> $stable(wr_cnt));

endmodule

bind rwd_arbiter rwd_arbiter_chk #(
    .RD_DEPTH (RD_DEPTH),
    .WR_DEPTH (WR_DEPTH),
    .HI_MARK  (HI_MARK),
    .LO_MARK  (LO_MARK),
    .IDX_W    (IDX_W),
    .RD_CNT_W (RD_CNT_W),
    .WR_CNT_W (WR_CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .gnt_valid  (gnt_valid),
    .gnt_write  (gnt_write),
    .gnt_idx    (gnt_idx),
    .drain_mode (drain_mode),
    .rd_ready   (rd_ready),
    .rd_cnt     (rd_cnt),
    .wr_cnt     (wr_cnt),
    .wr_full    (wr_full),
    .wr_push    (wr_push)
);

// File: tb/tb_rwd_arbiter.sv
// Self-checking bench: directed corners followed by seeded random traffic,
// compared each cycle against a queue model held in the bench.
module tb_rwd_arbiter;

    localparam int RD_D = 16;
    localparam int WR_D = 64;
    localparam int AW   = 16;
    localparam int HI   = 40;
    localparam int LO   = 20;
    localparam int IW   = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_push = 1'b0, wr_push = 1'b0;
    logic [AW-1:0] rd_push_addr = '0, wr_push_addr = '0;
    logic [RD_D-1:0] rd_ready = '0;
    logic [WR_D-1:0] wr_ready = '0;
    logic          gnt_valid, gnt_write, drain_mode, rd_full, wr_full;
    logic [IW-1:0] gnt_idx;
    logic [AW-1:0] gnt_addr;

    int checks = 0;
    int failures = 0;
    int rq[RD_D];
    int wq[WR_D];
    int rc = 0, wc = 0;
    bit mode = 1'b0;
    int next_addr = 1;

    always #10 clk = ~clk;

    rwd_arbiter #(.RD_DEPTH(RD_D), .WR_DEPTH(WR_D), .ADDR_W(AW),
                  .HI_MARK(HI), .LO_MARK(LO)) dut (
        .clk(clk), .rst_n(rst_n),
        .rd_push(rd_push), .rd_push_addr(rd_push_addr),
        .wr_push(wr_push), .wr_push_addr(wr_push_addr),
        .rd_ready(rd_ready), .wr_ready(wr_ready),
        .gnt_valid(gnt_valid), .gnt_write(gnt_write), .gnt_idx(gnt_idx),
        .gnt_addr(gnt_addr), .drain_mode(drain_mode),
        .rd_full(rd_full), .wr_full(wr_full)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Compare outputs with the model, then advance the model across one edge.
    task automatic step(input string tag);
        int re, we, ei, ea;
        bit ew, ev, nmode, rp, wp;
        #1;
        re = -1;
        for (int i = 0; i < rc; i++) if (rd_ready[i] && re < 0) re = i;
        we = -1;
        for (int i = 0; i < wc; i++) if (wr_ready[i] && we < 0) we = i;
        ew = mode || (rc == 0);
        ev = ew ? (we >= 0) : (re >= 0);
        ei = ew ? we : re;
        ea = ev ? (ew ? wq[ei] : rq[ei]) : 0;
        begin
            string t;
            t = (tag != "") ? tag : (mode ? "R6" : ((rc == 0) ? "R7" : "R2"));
            chk(t, int'(gnt_valid), int'(ev));
            if (ev) begin
                chk(t, int'(gnt_write), int'(ew));
                chk(t, int'(gnt_idx), ei);
                chk("R3", int'(gnt_addr), ea);
            end
        end
        chk(mode ? "R4" : "R5", int'(drain_mode), int'(mode));
        chk("R9", int'(rd_full), int'(rc == RD_D));
        chk("R9", int'(wr_full), int'(wc == WR_D));
        nmode = mode;
        if (!mode && wc > HI) nmode = 1'b1;
        if (mode && wc <= LO) nmode = 1'b0;
        rp = rd_push && (rc < RD_D);
        wp = wr_push && (wc < WR_D);
        if (ev && !ew) begin
            for (int i = ei; i < rc - 1; i++) rq[i] = rq[i+1];
            rc--;
        end
        if (ev && ew) begin
            for (int i = ei; i < wc - 1; i++) wq[i] = wq[i+1];
            wc--;
        end
        if (rp) begin rq[rc] = int'(rd_push_addr); rc++; end
        if (wp) begin wq[wc] = int'(wr_push_addr); wc++; end
        mode = nmode;
        @(negedge clk);
    endtask

    task automatic set_push(input bit r, input bit w);
        rd_push = r;
        wr_push = w;
        rd_push_addr = AW'(next_addr);
        wr_push_addr = AW'(next_addr + 1);
        next_addr += 2;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state while reset is held
        chk("R1", int'(gnt_valid), 0);
        chk("R1", int'(drain_mode), 0);
        chk("R1", int'(rd_full), 0);
        chk("R1", int'(wr_full), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: first cycle after reset, nothing issuable yet even with ready set
        rd_ready = '1; wr_ready = '1;
        step("R1");

        // Fill three reads and two writes with nothing issuable.
        rd_ready = '0; wr_ready = '0;
        set_push(1, 1); step("");
        set_push(1, 1); step("");
        set_push(1, 0); step("");
        set_push(0, 0);
        // R8: reads pending, none issuable, writes issuable: no grant
        wr_ready = '1; step("R8");
        wr_ready = '0;
        // R10: issuable bits only at positions beyond occupancy
        rd_ready = 16'hFFF8; step("R10");
        // R2: middle entry is the oldest issuable
        rd_ready = 16'h0006; step("R2");
        // R11: grant and push in the same cycle
        rd_ready = 16'h0001; set_push(1, 0); step("R11");
        set_push(0, 0);
        // R3: remaining reads leave in arrival order
        rd_ready = '1;
        for (int k = 0; k < 3; k++) step("R3");
        // R7: read queue empty, writes served in read mode
        rd_ready = '0; wr_ready = '1;
        for (int k = 0; k < 3; k++) step("R7");

        // Fill the write queue past the high mark and into full.
        wr_ready = '0;
        set_push(1, 0); step("");
        for (int k = 0; k < 66; k++) begin set_push(0, 1); step(""); end
        set_push(0, 0);
        // R9: push into the full queue is refused
        set_push(0, 1); step("R9");
        set_push(0, 0);
        // R6/R5: drain with reads issuable until the low mark
        rd_ready = '1; wr_ready = '1;
        for (int k = 0; k < 50; k++) step("");

        // Seeded random traffic.
        for (int k = 0; k < 4000; k++) begin
            set_push(($urandom % 3) == 0, ($urandom % 2) == 0);
            rd_ready = RD_D'($urandom);
            wr_ready = (($urandom % 4) == 0) ? {$urandom, $urandom} : '0;
            step("");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule